// File: doc/BRIEF.md
# Synchronous burst SRAM controller

This block is the cycle engine of a synchronous burst static memory. On every rising clock edge it samples three chip selects, two competing address strobes, a burst-step input, a write enable, the external address and the write data. From these it decides what kind of cycle the memory performs next. The cycle either loads a fresh address or steps or holds a two-bit linear burst counter in the low address bits. The result is a registered cycle code, the internal access address and read and write strobes. A small storage array sits behind it so that data written through the burst logic can be read back through the same logic.

The two strobes follow different rules. The host strobe always starts a read and is blocked entirely by one of the selects. The memory-controller strobe starts a read or a write, and any deselecting select combination cancels it. The read data path is gated by an output-enable pin that acts without the clock. A sleep request is resynchronised through two flops and takes priority over everything else. It abandons any access in flight and keeps the stored data intact. After the request drops, the block holds a short recovery window in which new activity is refused and flagged.

Top module: `sram_burst_ctrl`

## Requirements
- R1: While `rst_n` is low: `cyc_type` = 0, `acc_addr` = 0, `mem_rd` = `mem_wr` = 0, `dq_oe` = 0, `proto_err` = 0, `asleep` = 0, `ready` = 1. The cycle codes are 0 idle, 1 read start, 2 read step, 3 read hold, 4 write start, 5 write step, 6 write hold, 7 sleep.
- R2: A clock edge with `host_strb_n` low and the chip selected (`sel0_n` low, `sel1` high, `sel2_n` low) gives code 1 and loads `addr_in`, whatever `wr_n` is. This takes priority over `mc_strb_n`, and nothing is written.
- R3: A clock edge with `mc_strb_n` low, the host strobe inactive and the chip selected loads `addr_in`. It gives code 4 and writes `wdata` to that address when `wr_n` is low, and code 1 when `wr_n` is high.
- R4: With `mc_strb_n` low, `sel0_n` high, `sel1` low or `sel2_n` high gives code 0. With the host strobe low and `sel0_n` low, `sel1` low or `sel2_n` high gives code 0. With `sel0_n` high, the host strobe counts as inactive.
- R5: With both strobes inactive during a burst (previous code 1 to 6), `step_n` low gives code 2 (`wr_n` high) or 5 (`wr_n` low, writing `wdata`). The low two address bits become (previous + 1) mod 4 and the upper bits are kept.
- R6: With both strobes inactive during a burst, `step_n` high gives code 3 or 6 and repeats the current address. A hold with `wr_n` low rewrites that address.
- R7: A code-0 cycle leaves `acc_addr` unchanged. With both strobes inactive after code 0, the next code is 0 again.
- R8: `dq_oe` is high exactly when the current code is 1, 2 or 3 and `out_en_n` is low. It follows `out_en_n` without a clock edge. `dq_out` shows the stored word at `acc_addr` while `dq_oe` is high and 0 otherwise.
- R9: `asleep` rises on the second clock edge after `sleep_req` goes high, together with code 7. Code 7 and `asleep` hold while the request stays high. No write happens while the code is 7, and stored data is kept.
- R10: `asleep` falls on the second edge after `sleep_req` goes low, with code 0. `ready` is low while asleep and rises two edges after `asleep` falls.
- R11: Any select or strobe asserted at an edge where `asleep` and `ready` are both low is ignored. The code stays 0, the address is unchanged and nothing is written. It also sets `proto_err`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| out_en_n | input | 1 | Asynchronous read-data output enable, active low |
| sel0_n | input | 1 | Chip select, active low, also blocks the host strobe |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| host_strb_n | input | 1 | Host address strobe, active low, read only |
| mc_strb_n | input | 1 | Memory-controller address strobe, active low |
| step_n | input | 1 | Burst step when low, hold when high |
| wr_n | input | 1 | Write enable, active low |
| addr_in | input | AW | External address |
| wdata | input | DW | Write data |
| cyc_type | output | 3 | Code of the current cycle |
| acc_addr | output | AW | Internal access address |
| mem_rd | output | 1 | Current cycle is a read |
| mem_wr | output | 1 | Current cycle is a write |
| dq_out | output | DW | Read data, zero when not driven |
| dq_oe | output | 1 | Read data drive enable |
| asleep | output | 1 | Sleep has taken effect |
| ready | output | 1 | Awake and out of recovery |
| proto_err | output | 1 | Sticky recovery-window violation flag |

## Verification
Cycle code, access address and strobes are due one clock edge after the inputs that cause them. The bench drives on the falling edge, queues the expected code and address, and the monitor compares them 2 ns after the next rising edge. Read data and `dq_oe` are checked in that same cycle, and the output-enable gate is also toggled and checked between edges with no clock. Sleep entry and exit are counted edge by edge from the change of `sleep_req`: two edges to `asleep`, and two more after it falls to `ready`. The recovery violation is placed on the one edge inside that window.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE   = 3'd0,
    CYC_RD_NEW = 3'd1,
    CYC_RD_NXT = 3'd2,
    CYC_RD_HLD = 3'd3,
    CYC_WR_NEW = 3'd4,
    CYC_WR_NXT = 3'd5,
    CYC_WR_HLD = 3'd6,
    CYC_SLEEP  = 3'd7
  } cyc_e;

  function automatic logic is_read(input cyc_e c);
    return (c == CYC_RD_NEW) || (c == CYC_RD_NXT) || (c == CYC_RD_HLD);
  endfunction

  function automatic logic is_write(input cyc_e c);
    return (c == CYC_WR_NEW) || (c == CYC_WR_NXT) || (c == CYC_WR_HLD);
  endfunction

  function automatic logic is_burst(input cyc_e c);
    return is_read(c) || is_write(c);
  endfunction

endpackage

// File: rtl/sram_sleep_ctl.sv
module sram_sleep_ctl #(
  parameter int REC_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  output logic sleep_next,
  output logic asleep,
  output logic in_rec,
  output logic err_win,
  output logic ready
);
  localparam int CW = $clog2(REC_CYC + 2);
  localparam logic [CW-1:0] REC_LOAD = CW'(REC_CYC + 1);

  logic          sync1_q, sync2_q;
  logic [CW-1:0] rec_q, rec_d;

  // recovery count: loaded while asleep, counts down once awake
  always_comb begin
    rec_d = rec_q;
    if (sync1_q)
      rec_d = REC_LOAD;
    else if (rec_q != '0)
      rec_d = rec_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      rec_q   <= '0;
    end else begin
      sync1_q <= sleep_req;
      sync2_q <= sync1_q;
      rec_q   <= rec_d;
    end
  end

  assign sleep_next = sync1_q;
  assign asleep     = sync2_q;
  assign in_rec     = !sync1_q && (rec_q != '0);
  assign err_win    = in_rec && !sync2_q;
  assign ready      = !sync2_q && (rec_q == '0);

endmodule

// File: rtl/sram_cycle_dec.sv
module sram_cycle_dec
  import sram_burst_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel0_n,
  input  logic          sel1,
  input  logic          sel2_n,
  input  logic          host_strb_n,
  input  logic          mc_strb_n,
  input  logic          step_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr_in,
  input  logic          sleep_next,
  input  logic          in_rec,
  input  logic          err_win,
  output cyc_e          cyc_q,
  output logic [AW-1:0] addr_q,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          proto_err
);
  cyc_e          cyc_d;
  logic [AW-1:0] addr_d, addr_step;
  logic          chip_sel, host_act, mc_act, activity, err_d;

  assign chip_sel  = !sel0_n && sel1 && !sel2_n;
  assign host_act  = !host_strb_n && !sel0_n;
  assign mc_act    = !mc_strb_n;
  assign activity  = !sel0_n || sel1 || !sel2_n || !host_strb_n || !mc_strb_n;
  assign addr_step = {addr_q[AW-1:2], addr_q[1:0] + 2'd1};

  always_comb begin
    cyc_d  = CYC_IDLE;
    addr_d = addr_q;
    if (sleep_next) begin
      cyc_d = CYC_SLEEP;
    end else if (in_rec) begin
      cyc_d = CYC_IDLE;
    end else if (host_act) begin
      if (chip_sel) begin
        cyc_d  = CYC_RD_NEW;
        addr_d = addr_in;
      end
    end else if (mc_act) begin
      if (chip_sel) begin
        cyc_d  = wr_n ? CYC_RD_NEW : CYC_WR_NEW;
        addr_d = addr_in;
      end
    end else if (is_burst(cyc_q)) begin
      if (!step_n) begin
        cyc_d  = wr_n ? CYC_RD_NXT : CYC_WR_NXT;
        addr_d = addr_step;
      end else begin
        cyc_d  = wr_n ? CYC_RD_HLD : CYC_WR_HLD;
      end
    end
  end

  assign err_d = proto_err || (err_win && activity);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q     <= CYC_IDLE;
      addr_q    <= '0;
      proto_err <= 1'b0;
    end else begin
      cyc_q     <= cyc_d;
      addr_q    <= addr_d;
      proto_err <= err_d;
    end
  end

  assign wr_en   = is_write(cyc_d);
  assign wr_addr = addr_d;

endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
  import sram_burst_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DW      = 16,
  parameter int REC_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_req,
  input  logic          out_en_n,
  input  logic          sel0_n,
  input  logic          sel1,
  input  logic          sel2_n,
  input  logic          host_strb_n,
  input  logic          mc_strb_n,
  input  logic          step_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata,
  output logic [2:0]    cyc_type,
  output logic [AW-1:0] acc_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          asleep,
  output logic          ready,
  output logic          proto_err
);
  cyc_e          cyc;
  logic          sleep_next, in_rec, err_win, wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] rd_data;

  sram_sleep_ctl #(.REC_CYC(REC_CYC)) u_sleep (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_req  (sleep_req),
    .sleep_next (sleep_next),
    .asleep     (asleep),
    .in_rec     (in_rec),
    .err_win    (err_win),
    .ready      (ready)
  );

  sram_cycle_dec #(.AW(AW)) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel0_n      (sel0_n),
    .sel1        (sel1),
    .sel2_n      (sel2_n),
    .host_strb_n (host_strb_n),
    .mc_strb_n   (mc_strb_n),
    .step_n      (step_n),
    .wr_n        (wr_n),
    .addr_in     (addr_in),
    .sleep_next  (sleep_next),
    .in_rec      (in_rec),
    .err_win     (err_win),
    .cyc_q       (cyc),
    .addr_q      (acc_addr),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .proto_err   (proto_err)
  );

  sram_array #(.AW(AW), .DW(DW)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wdata),
    .rd_addr (acc_addr),
    .rd_data (rd_data)
  );

  assign cyc_type = cyc;
  assign mem_rd   = is_read(cyc);
  assign mem_wr   = is_write(cyc);
  assign dq_oe    = mem_rd && !out_en_n;
  assign dq_out   = dq_oe ? rd_data : '0;

endmodule

// File: rtl/sram_burst_ctrl_chk.sv
module sram_burst_ctrl_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_en_n,
  input logic [2:0]    cyc_type,
  input logic [AW-1:0] acc_addr,
  input logic          mem_wr,
  input logic          dq_oe,
  input logic          asleep,
  input logic          ready,
  input logic          proto_err
);
  // R9
  sleep_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (cyc_type == 3'd7 && !mem_wr));

  // R8
  drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!out_en_n && (cyc_type == 3'd1 || cyc_type == 3'd2 || cyc_type == 3'd3)));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  // R7
  idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 3'd0) |-> (acc_addr == $past(acc_addr)));

  // R6
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 3'd3 || cyc_type == 3'd6) |-> $stable(acc_addr));

  // R5
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 3'd2 || cyc_type == 3'd5) |->
      (acc_addr[1:0] == $past(acc_addr[1:0]) + 2'd1 &&
       acc_addr[AW-1:2] == $past(acc_addr[AW-1:2])));

  // R10
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> !ready);

endmodule

bind sram_burst_ctrl sram_burst_ctrl_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_en_n  (out_en_n),
  .cyc_type  (cyc_type),
  .acc_addr  (acc_addr),
  .mem_wr    (mem_wr),
  .dq_oe     (dq_oe),
  .asleep    (asleep),
  .ready     (ready),
  .proto_err (proto_err)
);

// File: tb/sram_burst_ctrl_bench.sv
module sram_burst_ctrl_bench;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n, sleep_req, out_en_n;
  logic          sel0_n, sel1, sel2_n, host_strb_n, mc_strb_n, step_n, wr_n;
  logic [AW-1:0] addr_in;
  logic [DW-1:0] wdata;
  logic [2:0]    cyc_type;
  logic [AW-1:0] acc_addr;
  logic          mem_rd, mem_wr, dq_oe, asleep, ready, proto_err;
  logic [DW-1:0] dq_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic slp_drive = 1'b0;

  string           req_q[$];
  logic [AW+2:0]   exp_q[$];

  always #5 clk = ~clk;

  sram_burst_ctrl #(.AW(AW), .DW(DW)) u_sram_burst_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .out_en_n(out_en_n),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .host_strb_n(host_strb_n), .mc_strb_n(mc_strb_n), .step_n(step_n),
    .wr_n(wr_n), .addr_in(addr_in), .wdata(wdata),
    .cyc_type(cyc_type), .acc_addr(acc_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .dq_out(dq_out), .dq_oe(dq_oe), .asleep(asleep), .ready(ready),
    .proto_err(proto_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: inputs on the falling edge, expected code/address queued
  task automatic step(input logic s0n, input logic s1, input logic s2n,
                      input logic hsn, input logic msn, input logic stn, input logic wn,
                      input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [2:0] ec, input logic [AW-1:0] ea, input string req);
    @(negedge clk);
    sleep_req   = slp_drive;
    sel0_n      = s0n;  sel1 = s1;  sel2_n = s2n;
    host_strb_n = hsn;  mc_strb_n = msn;
    step_n      = stn;  wr_n = wn;
    addr_in     = a;    wdata = d;
    req_q.push_back(req);
    exp_q.push_back({ec, ea});
  endtask

  task automatic idle(input logic [2:0] ec, input logic [AW-1:0] ea, input string req);
    step(1, 0, 1, 1, 1, 1, 1, 8'h00, 16'h0000, ec, ea, req);
  endtask

  task automatic observe();
    @(posedge clk);
    #3;
  endtask

  // monitor: compares each queued item just after its edge
  initial begin
    forever begin
      logic [AW+2:0] v;
      string r;
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        v = exp_q.pop_front();
        r = req_q.pop_front();
        check({r, " cycle/addr"}, {21'd0, cyc_type, acc_addr}, {21'd0, v});
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sleep_req = 1'b0; out_en_n = 1'b1;
    sel0_n = 1'b1; sel1 = 1'b0; sel2_n = 1'b1;
    host_strb_n = 1'b1; mc_strb_n = 1'b1; step_n = 1'b1; wr_n = 1'b1;
    addr_in = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #3;
    // R1 reset state
    check("R1 cyc", {29'd0, cyc_type}, 32'd0);
    check("R1 addr", {24'd0, acc_addr}, 32'd0);
    check("R1 strobes", {30'd0, mem_rd, mem_wr}, 32'd0);
    check("R1 dq_oe", {31'd0, dq_oe}, 32'd0);
    check("R1 flags", {29'd0, proto_err, asleep, ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 write start via controller strobe, R5 steps with wrap, R6 hold
    step(0, 1, 0, 1, 0, 1, 0, 8'h12, 16'hA0A0, 3'd4, 8'h12, "R3 write start");
    step(1, 0, 1, 1, 1, 0, 0, 8'h00, 16'hA1A1, 3'd5, 8'h13, "R5 write step");
    step(1, 0, 1, 1, 1, 0, 0, 8'h00, 16'hA2A2, 3'd5, 8'h10, "R5 write wrap");
    step(1, 0, 1, 1, 1, 1, 0, 8'h00, 16'hA3A3, 3'd6, 8'h10, "R6 write hold");
    step(1, 0, 1, 1, 1, 0, 0, 8'h00, 16'hA4A4, 3'd5, 8'h11, "R5 write step");

    // R2 host strobe read ignores wr_n
    out_en_n = 1'b0;
    step(0, 1, 0, 0, 1, 1, 0, 8'h12, 16'hFFFF, 3'd1, 8'h12, "R2 host read");
    observe();
    check("R2 no write, R8 data", {16'd0, dq_out}, 32'h0000A0A0);
    check("R8 drive", {30'd0, dq_oe, mem_rd}, 32'd3);
    out_en_n = 1'b1;
    #1;
    check("R8 async off", {15'd0, dq_oe, dq_out}, 32'd0);
    out_en_n = 1'b0;
    #1;
    check("R8 async on", {31'd0, dq_oe}, 32'd1);

    step(1, 0, 1, 1, 1, 0, 1, 8'h00, 16'h0000, 3'd2, 8'h13, "R5 read step");
    observe();
    check("R5 read data", {16'd0, dq_out}, 32'h0000A1A1);
    step(1, 0, 1, 1, 1, 0, 1, 8'h00, 16'h0000, 3'd2, 8'h10, "R5 read wrap");
    observe();
    check("R6 hold rewrote", {16'd0, dq_out}, 32'h0000A3A3);
    step(1, 0, 1, 1, 1, 1, 1, 8'h00, 16'h0000, 3'd3, 8'h10, "R6 read hold");

    // R4 deselect rules, R7 idle keeps address
    step(0, 0, 0, 1, 0, 1, 1, 8'h55, 16'h0000, 3'd0, 8'h10, "R4 mc sel1 low");
    observe();
    check("R8 idle no drive", {31'd0, dq_oe}, 32'd0);
    idle(3'd0, 8'h10, "R7 idle after idle");
    step(0, 1, 1, 0, 1, 0, 1, 8'h55, 16'h0000, 3'd0, 8'h10, "R4 host sel2 high");
    step(0, 1, 0, 1, 0, 1, 1, 8'h20, 16'h0000, 3'd1, 8'h20, "R3 read start");
    step(1, 1, 0, 0, 1, 0, 1, 8'h66, 16'h0000, 3'd2, 8'h21, "R4 host blocked");
    step(0, 1, 0, 0, 0, 1, 0, 8'h40, 16'h9999, 3'd1, 8'h40, "R2 host priority");
    observe();
    check("R2 no write strobe", {31'd0, mem_wr}, 32'd0);
    step(1, 1, 0, 0, 0, 1, 1, 8'h77, 16'h0000, 3'd0, 8'h40, "R4 mc sel0 high");

    // R9 sleep entry
    slp_drive = 1'b1;
    idle(3'd0, 8'h40, "R9 entry edge one");
    observe();
    check("R9 not yet asleep", {31'd0, asleep}, 32'd0);
    step(0, 1, 0, 1, 0, 1, 0, 8'h11, 16'hDEAD, 3'd7, 8'h40, "R9 sleep cycle");
    observe();
    check("R9 asleep", {30'd0, asleep, ready}, 32'd2);
    check("R9 no write strobe", {31'd0, mem_wr}, 32'd0);
    idle(3'd7, 8'h40, "R9 sleep held");

    // R10 exit and recovery, R11 violation
    slp_drive = 1'b0;
    idle(3'd7, 8'h40, "R10 exit edge one");
    observe();
    check("R10 still asleep", {31'd0, asleep}, 32'd1);
    idle(3'd0, 8'h40, "R10 awake");
    observe();
    check("R10 recovering", {30'd0, asleep, ready}, 32'd0);
    step(0, 1, 0, 1, 0, 1, 0, 8'h11, 16'hBEEF, 3'd0, 8'h40, "R11 ignored");
    observe();
    check("R11 flag", {30'd0, proto_err, ready}, 32'd2);
    idle(3'd0, 8'h40, "R10 last window");
    observe();
    check("R10 ready", {31'd0, ready}, 32'd1);
    step(0, 1, 0, 0, 1, 1, 1, 8'h11, 16'h0000, 3'd1, 8'h11, "R9 read back");
    observe();
    check("R9 R11 data kept", {16'd0, dq_out}, 32'h0000A4A4);
    check("R11 sticky", {31'd0, proto_err}, 32'd1);

    repeat (2) @(posedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule